// File: doc/BRIEF.md
# On-Demand ADC Conversion Sequencer

This block carries out one software-requested conversion of a single analog input. A requester presents a channel number on a valid/ready handshake. The sequencer then drives the converter's control lines through a fixed bring-up order. The extended-settling option is applied first. Next come the two quantised bias-current codes, together with the force-on control. The channel select and the conversion enable follow, and the end-of-conversion interrupt is unmasked last. Only then does the sequencer pulse start.

It waits for end-of-conversion and then captures the two result bytes. The response carries the low 12 bits of the 16-bit word. If end-of-conversion never arrives, a timeout derived from the clock-frequency parameter ends the wait with an error. In both cases the converter is shut down in a fixed order. The interrupt is masked again, then the select and enable are cleared, then force-on is released. The response is issued in the same cycle that force-on drops. A channel number above the highest valid channel is answered at once with an invalid-channel error, and the converter is never touched.

Top module: `adc_conv_seq`

## Requirements
- R1: `req_ready_o` is high only while the sequencer is idle. A request with `req_valid_i` and `req_ready_o` both high is accepted at that clock edge, and `req_ready_o` stays low from then until the cycle of its response.
- R2: After an accepted valid-channel request, the outputs change one per cycle in this order. `ext_delay_o` takes `cfg_ext_delay_i` one edge after acceptance. Then the current codes load and `force_on_o` rises. Then `sel_ch_o` takes the channel and `conv_en_o` rises. Then `eoc_unmask_o` rises.
- R3: `start_o` is a single-cycle pulse in the cycle after `eoc_unmask_o` rises, and it only occurs while force-on, enable and unmask are all high.
- R4: On end-of-conversion, the response returns `{result_hi_i, result_lo_i}` masked to its low 12 bits, with error code 0. Code 0 means success, 1 means timeout and 2 means invalid channel.
- R5: If `eoc_i` stays low for TIMEOUT_MS milliseconds of CLK_HZ cycles after start, the response has error code 1 and data 0.
- R6: Teardown runs after success and after timeout. `eoc_unmask_o` falls first. One cycle later `sel_ch_o` goes to 0 and `conv_en_o` falls. One cycle after that `force_on_o` falls and `rsp_valid_o` pulses.
- R7: A request whose channel exceeds MAX_CH (default 14) gets `rsp_valid_o` with error code 2 and data 0 in the cycle after acceptance. Force-on, enable and start stay low.
- R8: The channel-0 bias code on `isrc0_code_o` is 0 for `cfg_ch0_ua_i` up to 1, 1 up to 5, 2 up to 15, and 3 above 15.
- R9: The channel-3 bias code on `isrc3_code_o` is 0 for `cfg_ch3_ua_i` up to 1, 1 up to 10, 2 up to 400, and 3 above 400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Conversion request |
| req_ch_i | input | 4 | Requested channel |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| cfg_ch0_ua_i | input | 16 | Channel-0 bias current in microamps |
| cfg_ch3_ua_i | input | 16 | Channel-3 bias current in microamps |
| cfg_ext_delay_i | input | 1 | Extended settling option |
| ext_delay_o | output | 1 | Extended settling to converter |
| isrc0_code_o | output | 2 | Channel-0 bias current code |
| isrc3_code_o | output | 2 | Channel-3 bias current code |
| force_on_o | output | 1 | Hold converter powered |
| sel_ch_o | output | 4 | Selected channel |
| conv_en_o | output | 1 | Software conversion enable |
| eoc_unmask_o | output | 1 | End-of-conversion interrupt unmasked |
| start_o | output | 1 | Start pulse |
| eoc_i | input | 1 | End of conversion |
| result_lo_i | input | 8 | Result low byte |
| result_hi_i | input | 8 | Result high byte |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_data_o | output | 12 | Conversion result |
| rsp_err_o | output | 2 | 0 ok, 1 timeout, 2 invalid channel |

## Verification
If the sequencer state skips or repeats a step, a converter control line rises or falls one cycle early or late. That is visible in the very next cycle, because each step moves exactly one port. If the wait state ends too early or too late, the response carries the wrong error code. The latency from start to teardown also leaves its narrow window, which is measured in the timeout case. A stuck state shows up as `req_ready_o` never returning high.

// File: rtl/adc_conv_seq_pkg.sv
package adc_conv_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DLY, S_SRC, S_SEL, S_UNMASK, S_KICK, S_WAIT,
    S_TD_MASK, S_TD_SEL, S_TD_FORCE
  } seq_state_e;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_TIMEOUT = 2'd1;
  localparam logic [1:0] ERR_BADCH   = 2'd2;
endpackage

// File: rtl/isrc_quant.sv
module isrc_quant #(
  parameter int UA_W = 16,
  parameter int LIM0 = 1,
  parameter int LIM1 = 5,
  parameter int LIM2 = 15
) (
  input  logic [UA_W-1:0] ua_i,
  output logic [1:0]      code_o
);
  always_comb begin
    if (ua_i <= UA_W'(LIM0))      code_o = 2'd0;
    else if (ua_i <= UA_W'(LIM1)) code_o = 2'd1;
    else if (ua_i <= UA_W'(LIM2)) code_o = 2'd2;
    else                          code_o = 2'd3;
  end
endmodule

// File: rtl/tmo_timer.sv
module tmo_timer #(
  parameter longint unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));

  // R5: the wait window never runs past its limit
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(LIMIT));
endmodule

// File: rtl/result_fmt.sv
module result_fmt #(
  parameter int BYTE_W = 8,
  parameter int RES_W  = 12
) (
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  output logic [RES_W-1:0]  res_o
);
  localparam int RAW_W = 2 * BYTE_W;
  logic [RAW_W-1:0] raw;
  assign raw   = {hi_i, lo_i};
  assign res_o = raw[RES_W-1:0];
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_conv_seq_pkg::*;
#(
  parameter int CH_W       = 4,
  parameter int MAX_CH     = 14,
  parameter int UA_W       = 16,
  parameter int BYTE_W     = 8,
  parameter int RES_W      = 12,
  parameter int CLK_HZ     = 200_000_000,
  parameter int TIMEOUT_MS = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [CH_W-1:0]   req_ch_i,
  output logic              req_ready_o,
  input  logic [UA_W-1:0]   cfg_ch0_ua_i,
  input  logic [UA_W-1:0]   cfg_ch3_ua_i,
  input  logic              cfg_ext_delay_i,
  output logic              ext_delay_o,
  output logic [1:0]        isrc0_code_o,
  output logic [1:0]        isrc3_code_o,
  output logic              force_on_o,
  output logic [CH_W-1:0]   sel_ch_o,
  output logic              conv_en_o,
  output logic              eoc_unmask_o,
  output logic              start_o,
  input  logic              eoc_i,
  input  logic [BYTE_W-1:0] result_lo_i,
  input  logic [BYTE_W-1:0] result_hi_i,
  output logic              rsp_valid_o,
  output logic [RES_W-1:0]  rsp_data_o,
  output logic [1:0]        rsp_err_o
);
  localparam longint unsigned TMO_CYC =
    (longint'(CLK_HZ) / 1000) * longint'(TIMEOUT_MS);

  seq_state_e        state_q;
  logic [CH_W-1:0]   ch_q;
  logic [1:0]        code0, code3;
  logic [RES_W-1:0]  res;
  logic              expired;
  logic              bad_ch;

  isrc_quant #(.UA_W(UA_W), .LIM0(1), .LIM1(5),  .LIM2(15))
    u_q0 (.ua_i(cfg_ch0_ua_i), .code_o(code0));
  isrc_quant #(.UA_W(UA_W), .LIM0(1), .LIM1(10), .LIM2(400))
    u_q3 (.ua_i(cfg_ch3_ua_i), .code_o(code3));

  tmo_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(state_q == S_WAIT), .expired_o(expired)
  );

  result_fmt #(.BYTE_W(BYTE_W), .RES_W(RES_W)) u_fmt (
    .lo_i(result_lo_i), .hi_i(result_hi_i), .res_o(res)
  );

  assign req_ready_o = (state_q == S_IDLE);
  assign bad_ch      = req_ch_i > CH_W'(MAX_CH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      ch_q         <= '0;
      ext_delay_o  <= 1'b0;
      isrc0_code_o <= 2'd0;
      isrc3_code_o <= 2'd0;
      force_on_o   <= 1'b0;
      sel_ch_o     <= '0;
      conv_en_o    <= 1'b0;
      eoc_unmask_o <= 1'b0;
      start_o      <= 1'b0;
      rsp_valid_o  <= 1'b0;
      rsp_data_o   <= '0;
      rsp_err_o    <= ERR_NONE;
    end else begin
      start_o     <= 1'b0;
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          if (bad_ch) begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= ERR_BADCH;
            rsp_data_o  <= '0;
          end else begin
            ch_q    <= req_ch_i;
            state_q <= S_DLY;
          end
        end
        S_DLY: begin
          ext_delay_o <= cfg_ext_delay_i;
          state_q     <= S_SRC;
        end
        S_SRC: begin
          isrc0_code_o <= code0;
          isrc3_code_o <= code3;
          force_on_o   <= 1'b1;
          state_q      <= S_SEL;
        end
        S_SEL: begin
          sel_ch_o  <= ch_q;
          conv_en_o <= 1'b1;
          state_q   <= S_UNMASK;
        end
        S_UNMASK: begin
          eoc_unmask_o <= 1'b1;
          state_q      <= S_KICK;
        end
        S_KICK: begin
          start_o <= 1'b1;
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (eoc_i) begin
            rsp_data_o <= res;
            rsp_err_o  <= ERR_NONE;
            state_q    <= S_TD_MASK;
          end else if (expired) begin
            rsp_data_o <= '0;
            rsp_err_o  <= ERR_TIMEOUT;
            state_q    <= S_TD_MASK;
          end
        end
        S_TD_MASK: begin
          eoc_unmask_o <= 1'b0;
          state_q      <= S_TD_SEL;
        end
        S_TD_SEL: begin
          sel_ch_o  <= '0;
          conv_en_o <= 1'b0;
          state_q   <= S_TD_FORCE;
        end
        S_TD_FORCE: begin
          force_on_o  <= 1'b0;
          rsp_valid_o <= 1'b1;
          state_q     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_busy_after_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !bad_ch) |=> !req_ready_o);

  p_enable_after_force_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_en_o) |-> force_on_o && !eoc_unmask_o);

  p_unmask_after_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_unmask_o) |-> conv_en_o && force_on_o);

  p_start_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> eoc_unmask_o && conv_en_o && force_on_o);

  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_sel_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_en_o) |-> !eoc_unmask_o && force_on_o && (sel_ch_o == '0));

  p_force_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(force_on_o) |-> !conv_en_o && !eoc_unmask_o && rsp_valid_o);

  p_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && bad_ch) |=>
      rsp_valid_o && (rsp_err_o == ERR_BADCH) && !force_on_o && !start_o);
endmodule

// File: tb/adc_conv_seq_bench.sv
`timescale 1ns/1ps
module adc_conv_seq_bench;
  localparam int TB_CLK_HZ = 2000;
  localparam int TB_TMO_MS = 5000;
  localparam int TMO_CYC   = TB_CLK_HZ / 1000 * TB_TMO_MS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_ch = '0;
  logic        req_ready;
  logic [15:0] ua0 = '0, ua3 = '0;
  logic        ext_cfg = 1'b0;
  logic        ext_delay, force_on, conv_en, unmask, start;
  logic [1:0]  c0, c3, err;
  logic [3:0]  sel;
  logic        eoc = 1'b0;
  logic [7:0]  lo = '0, hi = '0;
  logic        rsp_valid;
  logic [11:0] data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_conv_seq #(.CLK_HZ(TB_CLK_HZ), .TIMEOUT_MS(TB_TMO_MS)) u_adc_conv_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ch_i(req_ch), .req_ready_o(req_ready),
    .cfg_ch0_ua_i(ua0), .cfg_ch3_ua_i(ua3), .cfg_ext_delay_i(ext_cfg),
    .ext_delay_o(ext_delay), .isrc0_code_o(c0), .isrc3_code_o(c3),
    .force_on_o(force_on), .sel_ch_o(sel), .conv_en_o(conv_en),
    .eoc_unmask_o(unmask), .start_o(start), .eoc_i(eoc),
    .result_lo_i(lo), .result_hi_i(hi),
    .rsp_valid_o(rsp_valid), .rsp_data_o(data), .rsp_err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // full conversion; eoc_dly < 0 means end-of-conversion never arrives
  task automatic run_conv(input logic [3:0] ch, input int eoc_dly,
                          input logic [7:0] l, input logic [7:0] h,
                          input logic [1:0] exp_err, input logic [11:0] exp_data,
                          input logic [1:0] exp_c0, input logic [1:0] exp_c3);
    int waited;
    @(negedge clk);
    req_valid = 1'b1; req_ch = ch;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    eq("R1 busy after accept", {31'd0, req_ready}, 0);
    eq("R2 force low before delay step", {31'd0, force_on}, 0);
    @(negedge clk);
    eq("R2 ext delay applied", {31'd0, ext_delay}, {31'd0, ext_cfg});
    eq("R2 force not yet", {31'd0, force_on}, 0);
    @(negedge clk);
    eq("R2 force on", {31'd0, force_on}, 1);
    eq("R2 enable not yet", {31'd0, conv_en}, 0);
    eq("R8 ch0 code", {30'd0, c0}, {30'd0, exp_c0});
    eq("R9 ch3 code", {30'd0, c3}, {30'd0, exp_c3});
    @(negedge clk);
    eq("R2 enable on", {31'd0, conv_en}, 1);
    eq("R2 select", {28'd0, sel}, {28'd0, ch});
    eq("R2 unmask not yet", {31'd0, unmask}, 0);
    @(negedge clk);
    eq("R2 unmask on", {31'd0, unmask}, 1);
    eq("R3 no early start", {31'd0, start}, 0);
    @(negedge clk);
    eq("R3 start pulse", {31'd0, start}, 1);
    waited = 0;
    if (eoc_dly >= 0) begin
      repeat (eoc_dly) begin @(negedge clk); waited++; end
      lo = l; hi = h; eoc = 1'b1;
      @(negedge clk); waited++; eoc = 1'b0;
      if (eoc_dly == 0) eq("R3 start single cycle", {31'd0, start}, 0);
    end
    while (unmask && waited < TMO_CYC + 50) begin @(negedge clk); waited++; end
    if (eoc_dly < 0)
      chk(waited >= TMO_CYC && waited <= TMO_CYC + 2, "R5 timeout latency",
          waited, TMO_CYC + 1);
    eq("R6 mask first, enable held", {30'd0, conv_en, force_on}, 32'h3);
    eq("R1 still busy", {31'd0, req_ready}, 0);
    @(negedge clk);
    eq("R6 select cleared", {28'd0, sel}, 0);
    eq("R6 enable off, force held", {30'd0, conv_en, force_on}, 32'h1);
    eq("R6 no response yet", {31'd0, rsp_valid}, 0);
    @(negedge clk);
    eq("R6 force off with response", {30'd0, force_on, rsp_valid}, 32'h1);
    eq(exp_err == 2'd0 ? "R4 error code" : "R5 error code", {30'd0, err}, {30'd0, exp_err});
    eq(exp_err == 2'd0 ? "R4 result" : "R5 result zero", {20'd0, data}, {20'd0, exp_data});
    eq("R1 ready again", {31'd0, req_ready}, 1);
    @(negedge clk);
    eq("R6 response single cycle", {31'd0, rsp_valid}, 0);
  endtask

  task automatic t_reset;
    eq("R1 ready at reset", {31'd0, req_ready}, 1);
    eq("R6 outputs idle at reset",
       {26'd0, force_on, conv_en, unmask, start, rsp_valid, ext_delay}, 0);
    eq("R6 select idle at reset", {28'd0, sel}, 0);
  endtask

  task automatic t_basic;
    ua0 = 16'd0; ua3 = 16'd0; ext_cfg = 1'b0;
    run_conv(4'd2, 0, 8'hCD, 8'hAB, 2'd0, 12'hBCD, 2'd0, 2'd0);
  endtask

  task automatic t_late_eoc;
    ua0 = 16'd5; ua3 = 16'd10; ext_cfg = 1'b1;
    run_conv(4'd0, 7, 8'h01, 8'hF5, 2'd0, 12'h501, 2'd1, 2'd1);
  endtask

  task automatic t_max_ch;
    ua0 = 16'd6; ua3 = 16'd11; ext_cfg = 1'b0;
    run_conv(4'd14, 2, 8'hFF, 8'h0F, 2'd0, 12'hFFF, 2'd2, 2'd2);
  endtask

  task automatic t_quant_edges;
    ua0 = 16'd15; ua3 = 16'd400;
    run_conv(4'd3, 1, 8'h00, 8'h00, 2'd0, 12'h000, 2'd2, 2'd2);
    ua0 = 16'd16; ua3 = 16'd401; ext_cfg = 1'b1;
    run_conv(4'd1, 40, 8'h34, 8'h12, 2'd0, 12'h234, 2'd3, 2'd3);
    ua0 = 16'd1; ua3 = 16'd1;
    run_conv(4'd7, 0, 8'h55, 8'hA0, 2'd0, 12'h055, 2'd0, 2'd0);
    ua0 = 16'd2; ua3 = 16'd2;
    run_conv(4'd9, 0, 8'h80, 8'h07, 2'd0, 12'h780, 2'd1, 2'd1);
    ua0 = 16'hFFFF; ua3 = 16'hFFFF;
    run_conv(4'd10, 0, 8'h01, 8'h00, 2'd0, 12'h001, 2'd3, 2'd3);
  endtask

  task automatic t_bad_ch;
    @(negedge clk);
    req_valid = 1'b1; req_ch = 4'd15;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    eq("R7 immediate response", {31'd0, rsp_valid}, 1);
    eq("R7 invalid code", {30'd0, err}, 2);
    eq("R7 data zero", {20'd0, data}, 0);
    for (int i = 0; i < 6; i++) begin
      eq("R7 converter untouched", {29'd0, force_on, conv_en, start}, 0);
      @(negedge clk);
    end
    eq("R7 ready after reject", {31'd0, req_ready}, 1);
  endtask

  task automatic t_timeout;
    ua0 = 16'd0; ua3 = 16'd0;
    run_conv(4'd5, -1, 8'h00, 8'h00, 2'd1, 12'h000, 2'd0, 2'd0);
  endtask

  task automatic t_recover;
    run_conv(4'd6, 3, 8'h9A, 8'h3C, 2'd0, 12'hC9A, 2'd0, 2'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_late_eoc();
    t_max_ch();
    t_quant_edges();
    t_bad_ch();
    t_timeout();
    t_recover();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule